// File: doc/BRIEF.md
# Digital AGC two-bit requantiser

This block sits between a 12-bit ADC and a correlator. It turns each offset-binary sample into a two-bit code made of a sign bit and a magnitude bit. The sign bit is the sample's top bit. The magnitude bit is set when the sample is far enough from mid-scale. "Far enough" is set by a threshold that the block recomputes at the end of each accumulation window, so the split between small and large samples follows changes in input power with no analog gain stage.

For each accepted sample, the low 11 bits are folded into a distance from mid-scale. That distance is summed over a window of 2^WIN_LOG2 valid samples. The window sum is divided by a shift to give the average distance, and the new threshold is that average plus one eighth of it. For Gaussian input this sets the magnitude bit on about 37% of samples. The default window of 2^16 samples gives an update period of about 1.31 ms at a 50 MHz sample rate.

Top module: `agc_requant`

## Requirements
- R1: One clock after a cycle with `in_vld` high, `sign_o` equals bit 11 of the sample accepted in that cycle.
- R2: `out_vld_o` is high in exactly the cycles that follow a cycle with `in_vld` high. The latency is one clock.
- R3: The folded magnitude is the low 11 bits when bit 11 is 1, and 2047 minus the low 11 bits when bit 11 is 0. `mag_o` is 1 when the folded magnitude is greater than or equal to the threshold that was on `thresh_o` in the cycle the sample was accepted.
- R4: While `rst_n` is low, `thresh_o` is THR_INIT (default 1024) and `sign_o`, `mag_o`, `out_vld_o` and `win_done_o` are 0. Reset also discards a partly filled window.
- R5: A window is 2^WIN_LOG2 valid samples. Cycles with `in_vld` low are not counted. `win_done_o` is a one-cycle pulse in the cycle after the window's last valid sample.
- R6: At the end of a window, the threshold becomes A + (A >> 3), saturated at 2047, where A is the window's folded sum shifted right by WIN_LOG2. The new value appears on `thresh_o` in the same cycle as `win_done_o`, and the next accepted sample is compared against it.
- R7: `thresh_o` changes only in a cycle where `win_done_o` is high.
- R8: Each window's sum starts from zero. Samples from earlier windows have no effect on the next threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample valid |
| in_sample | input | 12 | Offset-binary ADC sample |
| sign_o | output | 1 | Sign bit of the two-bit code |
| mag_o | output | 1 | Magnitude bit of the two-bit code |
| out_vld_o | output | 1 | Code valid, one clock after `in_vld` |
| thresh_o | output | 11 | Current magnitude threshold |
| win_done_o | output | 1 | One-cycle pulse at the end of each window |

## Verification
The bench targets the fold around mid-scale. Codes 2047 and 2048 must both fold to zero, and codes 0 and 4095 must both fold to 2047; an inverted fold would swap those pairs and flip the magnitude bits. It checks the comparison at exact equality with the threshold, where a strict compare would clear `mag_o`. It also checks the first sample after the done pulse, where a design that applies the new threshold one sample late would fail. A window whose scaled average exceeds 2047 shows whether the threshold saturates or wraps. Idle gaps inside a window and a reset in the middle of a window show whether the counter counts invalid cycles or keeps state from before the reset.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Two-bit code sent to the correlator
  typedef struct packed {
    logic sign;
    logic mag;
  } agc_code_t;

  localparam int unsigned AGC_SAMPLE_W = 12;

endpackage

// File: rtl/agc_fold.sv
module agc_fold #(
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned MAG_W   = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sign_o,
  output logic [MAG_W-1:0]    fold_o
);

  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [MAG_W-1:0] low;

  always_comb begin
    sign_o = sample_i[SAMPLE_W-1];
    low    = sample_i[MAG_W-1:0];
    // below mid-scale: measure the distance downward from code 2047
    if (sign_o) fold_o = low;
    else        fold_o = MAG_MAX - low;
  end

endmodule

// File: rtl/agc_accum.sv
module agc_accum #(
  parameter int unsigned MAG_W    = 11,
  parameter int unsigned WIN_LOG2 = 16,
  localparam int unsigned ACC_W   = MAG_W + WIN_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] fold_i,
  output logic             last_o,
  output logic [MAG_W-1:0] avg_o,
  output logic             done_o
);

  localparam logic [WIN_LOG2-1:0] CNT_LAST = '1;

  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]    acc_q, acc_d;
  logic [ACC_W-1:0]    sum_full;
  logic                done_q, done_d;

  always_comb begin
    sum_full = acc_q + ACC_W'(fold_i);
    last_o   = vld_i && (cnt_q == CNT_LAST);
    avg_o    = sum_full[ACC_W-1:WIN_LOG2];
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    done_d   = last_o;
    if (vld_i) begin
      if (last_o) begin
        cnt_d = '0;
        acc_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = sum_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (vld_i) begin
        cnt_q <= cnt_d;
        acc_q <= acc_d;
      end
    end
  end

  assign done_o = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && cnt_q != CNT_LAST) |=> !done_q);

endmodule

// File: rtl/agc_thresh.sv
module agc_thresh #(
  parameter int unsigned MAG_W     = 11,
  parameter int unsigned HEAD_SHIFT = 3,
  parameter int unsigned THR_INIT  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             done_i,
  input  logic [MAG_W-1:0] avg_i,
  output logic [MAG_W-1:0] thr_o
);

  localparam logic [MAG_W:0] SAT_LIM = {1'b0, {MAG_W{1'b1}}};

  logic [MAG_W-1:0] thr_q, thr_d;
  logic [MAG_W:0]   scaled;

  always_comb begin
    scaled = {1'b0, avg_i} + {1'b0, (avg_i >> HEAD_SHIFT)};
    if (scaled > SAT_LIM) thr_d = SAT_LIM[MAG_W-1:0];
    else                  thr_d = scaled[MAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= MAG_W'(THR_INIT);
    end else if (upd_i) begin
      thr_q <= thr_d;
    end
  end

  assign thr_o = thr_q;

  // R7
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> $stable(thr_q));

endmodule

// File: rtl/agc_quant.sv
module agc_quant
  import agc_pkg::*;
#(
  parameter int unsigned MAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             sign_i,
  input  logic [MAG_W-1:0] fold_i,
  input  logic [MAG_W-1:0] thr_i,
  output agc_code_t        code_o,
  output logic             vld_o
);

  agc_code_t code_q, code_d;
  logic      vld_q;

  always_comb begin
    code_d = code_q;
    if (vld_i) begin
      code_d.sign = sign_i;
      code_d.mag  = (fold_i >= thr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign vld_o  = vld_q;

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_q);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_q);

  // R1
  sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (code_q.sign == $past(sign_i)));

endmodule

// File: rtl/agc_requant.sv
module agc_requant
  import agc_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = AGC_SAMPLE_W,
  parameter int unsigned WIN_LOG2   = 16,
  parameter int unsigned HEAD_SHIFT = 3,
  parameter int unsigned THR_INIT   = 1 << (SAMPLE_W - 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                sign_o,
  output logic                mag_o,
  output logic                out_vld_o,
  output logic [SAMPLE_W-2:0] thresh_o,
  output logic                win_done_o
);

  localparam int unsigned MAG_W = SAMPLE_W - 1;

  logic             s_sign;
  logic [MAG_W-1:0] s_fold;
  logic             w_last;
  logic [MAG_W-1:0] w_avg;
  logic             w_done;
  logic [MAG_W-1:0] thr;
  agc_code_t        code;

  agc_fold #(.SAMPLE_W(SAMPLE_W)) u_fold (
    .sample_i (in_sample),
    .sign_o   (s_sign),
    .fold_o   (s_fold)
  );

  agc_accum #(.MAG_W(MAG_W), .WIN_LOG2(WIN_LOG2)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_vld),
    .fold_i (s_fold),
    .last_o (w_last),
    .avg_o  (w_avg),
    .done_o (w_done)
  );

  agc_thresh #(.MAG_W(MAG_W), .HEAD_SHIFT(HEAD_SHIFT), .THR_INIT(THR_INIT)) u_thresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (w_last),
    .done_i (w_done),
    .avg_i  (w_avg),
    .thr_o  (thr)
  );

  agc_quant #(.MAG_W(MAG_W)) u_quant (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_vld),
    .sign_i (s_sign),
    .fold_i (s_fold),
    .thr_i  (thr),
    .code_o (code),
    .vld_o  (out_vld_o)
  );

  assign sign_o     = code.sign;
  assign mag_o      = code.mag;
  assign thresh_o   = thr;
  assign win_done_o = w_done;

endmodule

// File: tb/sim_agc_requant.sv
module sim_agc_requant;

  localparam int PERIOD = 10;
  localparam int WL2    = 3;
  localparam int NWIN   = 1 << WL2;

  // entry: {sample[11:0], expected sign, expected mag} for the first window, threshold 1024
  localparam logic [13:0] VEC [NWIN] = '{
    {12'h000, 1'b0, 1'b1},  // fold 2047
    {12'hFFF, 1'b1, 1'b1},  // fold 2047
    {12'h800, 1'b1, 1'b0},  // fold 0
    {12'h7FF, 1'b0, 1'b0},  // fold 0
    {12'hC00, 1'b1, 1'b1},  // fold 1024 equal to threshold
    {12'hBFF, 1'b1, 1'b0},  // fold 1023
    {12'h3FF, 1'b0, 1'b1},  // fold 1024
    {12'h400, 1'b0, 1'b0}   // fold 1023
  };

  logic        clk, rst_n, in_vld;
  logic [11:0] in_sample;
  logic        sign_o, mag_o, out_vld_o, win_done_o;
  logic [10:0] thresh_o;

  int checks = 0;
  int errors = 0;
  int thr_m, sum_m, cnt_m;

  agc_requant #(.WIN_LOG2(WL2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(in_sample),
    .sign_o(sign_o), .mag_o(mag_o), .out_vld_o(out_vld_o),
    .thresh_o(thresh_o), .win_done_o(win_done_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    thr_m = 1024; sum_m = 0; cnt_m = 0;
  endtask

  // drive one valid sample and check the cycle after it
  task automatic send(input logic [11:0] s);
    int fold, avg, t;
    bit esign, emag, edone;
    in_vld = 1'b1; in_sample = s;
    @(posedge clk);
    @(negedge clk);
    esign = s[11];
    fold  = esign ? int'(s[10:0]) : 2047 - int'(s[10:0]);
    emag  = (fold >= thr_m);
    sum_m += fold; cnt_m++;
    edone = 1'b0;
    if (cnt_m == NWIN) begin
      avg   = sum_m >> WL2;
      t     = avg + (avg >> 3);
      thr_m = (t > 2047) ? 2047 : t;
      edone = 1'b1; cnt_m = 0; sum_m = 0;
    end
    check(out_vld_o == 1'b1, "R2 out_vld", out_vld_o, 1);
    check(sign_o == esign, "R1 sign", sign_o, esign);
    check(mag_o == emag, "R3 mag", mag_o, emag);
    check(win_done_o == edone, "R5 done", win_done_o, edone);
    check(thresh_o == thr_m, "R6 thresh", thresh_o, thr_m);
    in_vld = 1'b0;
  endtask

  task automatic idle();
    in_vld = 1'b0; in_sample = 12'hA5A;
    @(posedge clk);
    @(negedge clk);
    check(out_vld_o == 1'b0, "R2 idle out_vld", out_vld_o, 0);
    check(win_done_o == 1'b0, "R5 idle done", win_done_o, 0);
    check(thresh_o == thr_m, "R7 idle thresh", thresh_o, thr_m);
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_sample = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R4 reset state
    check(thresh_o == 1024, "R4 reset thresh", thresh_o, 1024);
    check(out_vld_o == 0 && win_done_o == 0, "R4 reset strobes", {out_vld_o, win_done_o}, 0);
    check(sign_o == 0 && mag_o == 0, "R4 reset code", {sign_o, mag_o}, 0);
    rst_n = 1'b1;
    idle();

    // first window from the table; the eighth entry gives threshold 1150 (R6)
    for (int i = 0; i < NWIN; i++) begin
      send(VEC[i][13:2]);
      check(sign_o == VEC[i][1], "R1 table sign", sign_o, VEC[i][1]);
      check(mag_o == VEC[i][0], "R3 table mag", mag_o, VEC[i][0]);
    end
    check(thresh_o == 1150, "R6 first window thresh", thresh_o, 1150);
    idle();

    // R6 new threshold applies at once; R3 boundary at equality
    send(12'd3198);   // fold 1150 -> 1
    send(12'd3197);   // fold 1149 -> 0
    idle(); idle();   // R5 gaps inside the window are not counted
    for (int i = 0; i < 6; i++) begin
      send(12'h000);
      if (i == 2) idle();
    end
    // R6 saturation: avg 1822 scales to 2049, clipped to 2047
    check(thresh_o == 2047, "R6 saturated thresh", thresh_o, 2047);

    // R8 new window starts from zero
    send(12'h000);    // fold 2047 >= 2047 -> 1
    send(12'h001);    // fold 2046 -> 0
    for (int i = 0; i < 6; i++) send(12'h800);
    check(thresh_o == 574, "R8 third window thresh", thresh_o, 574);

    // R4 reset in the middle of a window
    send(12'h000); send(12'h000); send(12'h000);
    #(PERIOD/4) rst_n = 1'b0;
    #1;
    check(thresh_o == 1024, "R4 async reset thresh", thresh_o, 1024);
    check(out_vld_o == 0, "R4 async reset vld", out_vld_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    idle();
    for (int i = 0; i < NWIN; i++) send(12'hC00);
    check(thresh_o == 1152, "R4 R8 window after reset", thresh_o, 1152);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule